// File: doc/BRIEF.md
# I2C Slave Receiver with Two-Phase 10-Bit Address Match

This block is an I2C slave that only receives, and it answers to a 10-bit address. It does not hold the whole address. It has one 8-bit compare register that the host reloads between the two address bytes. The first byte on the bus carries the fixed 11110 prefix, address bits 9:8 and the R/W bit. When that byte matches, the slave acknowledges it, raises an update-address flag and an interrupt, and holds SCL low. The host then writes the low eight address bits into the compare register, and that write releases the clock. The second byte is compared against the new value. After it, the host puts the high pattern back, and the slave receives data bytes until a stop condition.

The bus pins are open-drain. `sclIn` and `sdaIn` sample the wire, and `sclOe` and `sdaOe` pull it low when set. The host port is a 2-bit register address with write and read strobes:

| Address | Register | Contents |
|---|---|---|
| 0 | Compare | Bits 7:1 are compared in the first phase; all 8 bits are compared in the second phase |
| 1 | Receive buffer | Last received data byte |
| 2 | Control | Bit 0 stretch enable, bit 1 interrupt-on-start enable, bit 2 clock release |
| 3 | Status | Bit 0 interrupt, bit 1 update-address, bit 2 buffer full, bit 3 start seen, bit 4 stop seen |

The control register resets to 0x04, with the clock released. Every other register resets to zero. A write to the compare register also clears the update-address flag and the address-phase hold.

Top module: `i2c_slave10_rx`

## Requirements
- R1: A start condition (SDA falling while SCL is high) sets status bit 3 and clears status bit 4. It sets the interrupt flag (status bit 0) only when control bit 1 is set.
- R2: A first byte whose bits 7:1 equal bits 7:1 of the compare register, with bit 0 (R/W) equal to 0, is acknowledged. Status bits 1 and 0 are then set at the end of the ACK clock.
- R3: After an acknowledged address byte, `sclOe` holds SCL low. It goes low two cycles after the host writes the compare register, and that write also clears status bit 1.
- R4: The second byte is compared with all eight compare-register bits. On a match it is acknowledged, and status bits 1 and 0 are set.
- R5: A second byte that does not match is not acknowledged, and SCL is not held. Status bits 1 and 0 are still set. Status bit 2 stays clear and control bit 2 is unchanged. Later bytes of that transfer are not acknowledged.
- R6: A first byte that differs in bits 7:1, or that has R/W equal to 1, is not acknowledged. It sets no flag, and the rest of the transfer is ignored.
- R7: A compare-register write made during the ACK clock takes effect only after that clock's falling edge. Until then, reads of address 0 return the old value.
- R8: Each data byte is acknowledged on the 9th clock. At the end of that clock the byte is placed in the receive buffer, and status bits 2 and 0 are set.
- R9: With control bit 0 set, each data byte clears control bit 2, and `sclOe` holds SCL low. Writing control bit 2 back to 1 releases SCL.
- R10: A host read of address 1 clears status bit 2.
- R11: A stop condition (SDA rising while SCL is high) sets status bit 4 and returns the slave to idle. A new transfer then needs a new start and a new address match.
- R12: Writing 1 to status bits 0, 1, 3 or 4 clears that bit. Writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled level of the SCL wire |
| sdaIn | input | 1 | Sampled level of the SDA wire |
| sclOe | output | 1 | Pull SCL low when 1 |
| sdaOe | output | 1 | Pull SDA low when 1 |
| hostWe | input | 1 | Host register write strobe |
| hostRe | input | 1 | Host register read strobe |
| hostAddr | input | 2 | Host register address |
| hostWrData | input | 8 | Host write data |
| hostRdData | output | 8 | Host read data (combinational) |
| irq | output | 1 | Interrupt flag level |

## Verification
The first-phase match is tried with every combination of the two high address bits and the R/W bit. This separates a correct compare from one that ignores R/W or only checks the prefix. The second-phase match is tried with the exact low byte and with each single-bit corruption of it. This shows that every one of the eight bits takes part in the compare, and that a mismatch still raises the update-address and interrupt flags. Data bytes of varied bit patterns show that the byte is shifted in MSB first. Separate runs cover stretching on and off, and a compare write made inside the ACK clock, to show both the hold behaviour and the deferred address update.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HI,
    PH_LO,
    PH_DATA,
    PH_SKIP
  } phase_e;

  // Strobes from the bus controller to the datapath.
  typedef struct packed {
    logic rxBit;
    logic shiftIn;
    logic ackBusy;
    logic uaEvent;
    logic uaStretch;
    logic dataDone;
    logic startEv;
    logic stopEv;
  } strobe_t;

  localparam logic [1:0] REG_CMP  = 2'd0;
  localparam logic [1:0] REG_BUF  = 2'd1;
  localparam logic [1:0] REG_CTL  = 2'd2;
  localparam logic [1:0] REG_STAT = 2'd3;
endpackage

// File: rtl/i2c10_ctrl.sv
module i2c10_ctrl
  import i2c10_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  logic    sdaIn,
  input  logic    matchHi,
  input  logic    matchLo,
  output strobe_t st,
  output logic    sdaOe
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclP, sdaP;
  logic sclRise, sclFall, startDet, stopDet;
  phase_e phase;
  logic [CNT_W-1:0] bitCnt;
  logic ackActive, ackMatch, ackOk, byteDone, active, ackEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclP    <= sclS;
      sdaP    <= sdaS;
    end
  end

  assign sclS     = sclSync[SYNC_STAGES-1];
  assign sdaS     = sdaSync[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;
  assign active   = (phase != PH_IDLE);
  assign byteDone = (bitCnt == LAST_BIT);
  assign ackEnd   = active & sclFall & ackActive;

  always_comb begin
    ackOk = 1'b0;
    case (phase)
      PH_HI:   ackOk = matchHi;
      PH_LO:   ackOk = matchLo;
      PH_DATA: ackOk = 1'b1;
      default: ackOk = 1'b0;
    endcase
  end

  always_comb begin
    st.rxBit     = sdaS;
    st.shiftIn   = active & sclRise & ~byteDone & ~startDet & ~stopDet;
    st.ackBusy   = ackActive;
    st.uaEvent   = ackEnd & (((phase == PH_HI) & ackMatch) | (phase == PH_LO));
    st.uaStretch = ackEnd & ackMatch & ((phase == PH_HI) | (phase == PH_LO));
    st.dataDone  = ackEnd & (phase == PH_DATA);
    st.startEv   = startDet;
    st.stopEv    = stopDet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      bitCnt    <= '0;
      ackActive <= 1'b0;
      ackMatch  <= 1'b0;
      sdaOe     <= 1'b0;
    end else if (startDet) begin
      phase     <= PH_HI;
      bitCnt    <= '0;
      ackActive <= 1'b0;
      sdaOe     <= 1'b0;
    end else if (stopDet) begin
      phase     <= PH_IDLE;
      bitCnt    <= '0;
      ackActive <= 1'b0;
      sdaOe     <= 1'b0;
    end else if (active) begin
      if (st.shiftIn) bitCnt <= bitCnt + 1'b1;
      if (sclFall && byteDone && !ackActive) begin
        ackActive <= 1'b1;
        ackMatch  <= ackOk;
        sdaOe     <= ackOk;
      end
      if (ackEnd) begin
        ackActive <= 1'b0;
        sdaOe     <= 1'b0;
        bitCnt    <= '0;
        case (phase)
          PH_HI:   phase <= ackMatch ? PH_LO : PH_SKIP;
          PH_LO:   phase <= ackMatch ? PH_DATA : PH_SKIP;
          default: phase <= phase;
        endcase
      end
    end
  end

  // R6: the slave pulls SDA only in a phase that may acknowledge
  assert_no_ack_when_skipping_R6: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> (phase == PH_HI || phase == PH_LO || phase == PH_DATA));
  // R8: SDA is driven only inside the acknowledge clock
  assert_ack_inside_window_R8: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> ackActive);
  // R11: a stop leaves the controller idle
  assert_stop_goes_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    stopDet && !startDet |=> phase == PH_IDLE && !sdaOe);
endmodule

// File: rtl/i2c10_dp.sv
module i2c10_dp
  import i2c10_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     st,
  input  logic        hostWe,
  input  logic        hostRe,
  input  logic [1:0]  hostAddr,
  input  logic [7:0]  hostWrData,
  output logic [7:0]  hostRdData,
  output logic        matchHi,
  output logic        matchLo,
  output logic        sclOe,
  output logic        irq
);
  logic [BYTE_W-1:0] shiftReg, addrReg, pendAddr, rxBuf;
  logic pendValid, applyAddr;
  logic stretchEn, startIrqEn, clkRelease;
  logic irqFlag, uaFlag, bufFull, startSeen, stopSeen, uaHold;
  logic wrCmp, wrCtl, wrStat, rdBuf;

  assign wrCmp     = hostWe && hostAddr == REG_CMP;
  assign wrCtl     = hostWe && hostAddr == REG_CTL;
  assign wrStat    = hostWe && hostAddr == REG_STAT;
  assign rdBuf     = hostRe && hostAddr == REG_BUF;
  assign applyAddr = pendValid && !st.ackBusy;

  assign matchHi = (shiftReg[BYTE_W-1:1] == addrReg[BYTE_W-1:1]) && !shiftReg[0];
  assign matchLo = (shiftReg == addrReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      addrReg   <= '0;
      pendAddr  <= '0;
      pendValid <= 1'b0;
    end else begin
      if (st.shiftIn) shiftReg <= {shiftReg[BYTE_W-2:0], st.rxBit};
      if (wrCmp) begin
        pendAddr  <= hostWrData;
        pendValid <= 1'b1;
      end else if (applyAddr) begin
        addrReg   <= pendAddr;
        pendValid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBuf      <= '0;
      stretchEn  <= 1'b0;
      startIrqEn <= 1'b0;
      clkRelease <= 1'b1;
      irqFlag    <= 1'b0;
      uaFlag     <= 1'b0;
      bufFull    <= 1'b0;
      startSeen  <= 1'b0;
      stopSeen   <= 1'b0;
      uaHold     <= 1'b0;
    end else begin
      if (wrCtl) begin
        stretchEn  <= hostWrData[0];
        startIrqEn <= hostWrData[1];
        clkRelease <= hostWrData[2];
      end
      if (wrStat) begin
        if (hostWrData[0]) irqFlag   <= 1'b0;
        if (hostWrData[1]) uaFlag    <= 1'b0;
        if (hostWrData[3]) startSeen <= 1'b0;
        if (hostWrData[4]) stopSeen  <= 1'b0;
      end
      if (rdBuf) bufFull <= 1'b0;
      if (applyAddr) begin
        uaFlag <= 1'b0;
        uaHold <= 1'b0;
      end
      if (st.startEv) begin
        startSeen <= 1'b1;
        stopSeen  <= 1'b0;
        if (startIrqEn) irqFlag <= 1'b1;
      end
      if (st.stopEv) begin
        stopSeen  <= 1'b1;
        startSeen <= 1'b0;
        uaHold    <= 1'b0;
      end
      if (st.uaEvent) begin
        uaFlag  <= 1'b1;
        irqFlag <= 1'b1;
      end
      if (st.uaStretch) uaHold <= 1'b1;
      if (st.dataDone) begin
        rxBuf   <= shiftReg;
        bufFull <= 1'b1;
        irqFlag <= 1'b1;
        if (stretchEn) clkRelease <= 1'b0;
      end
    end
  end

  always_comb begin
    case (hostAddr)
      REG_CMP: hostRdData = addrReg;
      REG_BUF: hostRdData = rxBuf;
      REG_CTL: hostRdData = {5'b0, clkRelease, startIrqEn, stretchEn};
      default: hostRdData = {3'b0, stopSeen, startSeen, bufFull, uaFlag, irqFlag};
    endcase
  end

  assign sclOe = uaHold | ~clkRelease;
  assign irq   = irqFlag;

  // R7: the compare register cannot change right after an ACK-clock cycle
  assert_cmp_frozen_in_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
    st.ackBusy |=> $stable(addrReg));
  // R8: the buffer-full flag only rises from a completed data byte
  assert_buf_full_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufFull) |-> $past(st.dataDone));
  // R3: an address-phase hold always comes with the update-address flag
  assert_hold_has_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(uaHold) |-> uaFlag);
  // R9: stretching clears the release bit and pulls SCL
  assert_stretch_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    st.dataDone && stretchEn |=> !clkRelease && sclOe);
  // R11: a stop drops any address-phase hold
  assert_stop_drops_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    st.stopEv |=> !uaHold);
endmodule

// File: rtl/i2c_slave10_rx.sv
module i2c_slave10_rx
  import i2c10_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe,
  input  logic       hostWe,
  input  logic       hostRe,
  input  logic [1:0] hostAddr,
  input  logic [7:0] hostWrData,
  output logic [7:0] hostRdData,
  output logic       irq
);
  strobe_t st;
  logic matchHi, matchLo;

  i2c10_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .matchHi(matchHi), .matchLo(matchLo), .st(st), .sdaOe(sdaOe)
  );

  i2c10_dp uDp (
    .clk(clk), .rstN(rstN), .st(st),
    .hostWe(hostWe), .hostRe(hostRe), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .matchHi(matchHi), .matchLo(matchLo), .sclOe(sclOe), .irq(irq)
  );
endmodule

// File: tb/sim_i2c_slave10_rx.sv
module sim_i2c_slave10_rx;
  localparam int HALF = 20;
  localparam logic [7:0] HI_PAT = 8'hF4;
  localparam logic [7:0] LO_PAT = 8'h3C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic mScl = 1'b1, mSda = 1'b1;
  logic sclOe, sdaOe, busScl, busSda, irq;
  logic hostWe = 1'b0, hostRe = 1'b0;
  logic [1:0] hostAddr = 2'd0;
  logic [7:0] hostWrData = 8'd0, hostRdData;
  int tests = 0, fails = 0;

  assign busScl = mScl & ~sclOe;
  assign busSda = mSda & ~sdaOe;

  i2c_slave10_rx u0 (
    .clk(clk), .rstN(rstN), .sclIn(busScl), .sdaIn(busSda),
    .sclOe(sclOe), .sdaOe(sdaOe), .hostWe(hostWe), .hostRe(hostRe),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [7:0] d);
    hostAddr = a; hostWrData = d; hostWe = 1'b1;
    waitCyc(1);
    hostWe = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [7:0] d);
    hostAddr = a; hostRe = 1'b1;
    #1 d = hostRdData;
    waitCyc(1);
    hostRe = 1'b0;
  endtask

  task automatic i2cStart();
    mSda = 1'b1; waitCyc(HALF);
    mScl = 1'b1;
    while (!busScl) waitCyc(1);
    waitCyc(HALF);
    mSda = 1'b0; waitCyc(HALF);
    mScl = 1'b0; waitCyc(HALF);
  endtask

  task automatic i2cStop();
    mSda = 1'b0; waitCyc(HALF);
    mScl = 1'b1;
    while (!busScl) waitCyc(1);
    waitCyc(HALF);
    mSda = 1'b1; waitCyc(HALF);
  endtask

  task automatic sendBit(input logic b);
    mSda = b; waitCyc(HALF);
    mScl = 1'b1;
    while (!busScl) waitCyc(1);
    waitCyc(HALF);
    mScl = 1'b0; waitCyc(2);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit midWrite,
                          input logic [7:0] oldCmp, output bit acked);
    logic [7:0] rd;
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    mSda = 1'b1; waitCyc(HALF);
    mScl = 1'b1;
    while (!busScl) waitCyc(1);
    waitCyc(HALF / 2);
    acked = !busSda;
    if (midWrite) begin
      hostWrite(2'd0, 8'h55);
      waitCyc(2);
      hostRead(2'd0, rd);
      chk("R7 compare unchanged inside ACK clock", rd, oldCmp);
    end
    waitCyc(HALF / 2);
    mScl = 1'b0; waitCyc(6);
    if (midWrite) begin
      hostRead(2'd0, rd);
      chk("R7 compare updated after ACK clock", rd, 8'h55);
    end
  endtask

  task automatic addrSeq();
    bit a;
    i2cStart();
    sendByte(HI_PAT, 1'b0, 8'h0, a);
    hostWrite(2'd0, LO_PAT); waitCyc(2);
    sendByte(LO_PAT, 1'b0, 8'h0, a);
    hostWrite(2'd0, HI_PAT); waitCyc(2);
    hostWrite(2'd3, 8'h1F);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R11 watchdog actual=stalled expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    bit ack;
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(2);
    // reset state
    hostRead(2'd3, rd); chk("R12 reset status", rd, 8'h00);
    hostRead(2'd2, rd); chk("R9 reset control", rd, 8'h04);
    chk("R3 reset sclOe", sclOe, 1'b0);
    chk("R8 reset sdaOe", sdaOe, 1'b0);
    chk("R1 reset irq", irq, 1'b0);

    hostWrite(2'd0, HI_PAT); waitCyc(2);
    hostWrite(2'd3, 8'h1F);

    // R1 start without and with interrupt-on-start
    i2cStart();
    hostRead(2'd3, rd); chk("R1 start flag, no irq", rd, 8'h08);
    i2cStop();
    hostRead(2'd3, rd); chk("R11 stop flag", rd, 8'h10);
    hostWrite(2'd3, 8'h1F);
    hostWrite(2'd2, 8'h06);
    i2cStart();
    chk("R1 irq on start enabled", irq, 1'b1);
    hostWrite(2'd3, 8'h01);
    hostRead(2'd3, rd); chk("R12 W1C irq only", rd, 8'h08);
    i2cStop();
    hostWrite(2'd3, 8'h1F);
    hostWrite(2'd2, 8'h04);

    // R2 / R6 sweep of high bits and R/W
    for (int t = 0; t < 8; t++) begin
      logic [7:0] b;
      bit m;
      b = {5'b11110, 3'(t)};
      m = (b == HI_PAT);
      i2cStart();
      sendByte(b, 1'b0, 8'h0, ack);
      chk($sformatf("R2 R6 ack for first byte %0h", b), ack, m);
      hostRead(2'd3, rd);
      chk($sformatf("R2 R6 flags for first byte %0h", b), rd & 8'h03, m ? 8'h03 : 8'h00);
      chk($sformatf("R3 hold after first byte %0h", b), sclOe, m);
      if (m) begin
        hostWrite(2'd0, HI_PAT); waitCyc(2);
        chk("R3 compare write releases SCL", sclOe, 1'b0);
        hostRead(2'd3, rd); chk("R3 compare write clears update flag", rd & 8'h02, 8'h00);
      end
      i2cStop();
      hostWrite(2'd3, 8'h1F);
    end

    // R4 / R5 sweep of low byte: exact and each single-bit error
    for (int i = 0; i < 9; i++) begin
      logic [7:0] lo;
      bit m;
      lo = (i == 0) ? LO_PAT : (LO_PAT ^ (8'h01 << (i - 1)));
      m = (i == 0);
      i2cStart();
      sendByte(HI_PAT, 1'b0, 8'h0, ack);
      hostWrite(2'd0, LO_PAT); waitCyc(2);
      hostWrite(2'd3, 8'h1F);
      sendByte(lo, 1'b0, 8'h0, ack);
      chk($sformatf("R4 R5 ack for low byte %0h", lo), ack, m);
      hostRead(2'd3, rd);
      chk($sformatf("R4 R5 flags for low byte %0h", lo), rd & 8'h07, 8'h03);
      chk($sformatf("R5 hold for low byte %0h", lo), sclOe, m);
      hostRead(2'd2, rd); chk("R5 release bit unchanged", rd, 8'h04);
      if (m) begin
        hostWrite(2'd3, 8'h02);
        hostRead(2'd3, rd); chk("R12 W1C update flag only", rd & 8'h03, 8'h01);
      end
      hostWrite(2'd0, HI_PAT); waitCyc(2);
      hostWrite(2'd3, 8'h1F);
      sendByte(8'hA5, 1'b0, 8'h0, ack);
      chk("R5 R8 data ack after low phase", ack, m);
      hostRead(2'd3, rd); chk("R5 R8 buffer full after data", rd & 8'h04, m ? 8'h04 : 8'h00);
      if (m) begin
        hostRead(2'd1, rd); chk("R8 buffer value", rd, 8'hA5);
        hostRead(2'd3, rd); chk("R10 read clears buffer full", rd & 8'h04, 8'h00);
      end
      i2cStop();
      hostWrite(2'd3, 8'h1F);
    end

    // R8 / R10 data patterns without stretching
    addrSeq();
    for (int k = 0; k < 6; k++) begin
      logic [7:0] d;
      d = 8'(k * 8'h3B + 8'h11);
      sendByte(d, 1'b0, 8'h0, ack);
      chk("R8 data ack", ack, 1'b1);
      hostRead(2'd3, rd); chk("R8 status after data", rd & 8'h07, 8'h05);
      chk("R9 no hold with stretch off", sclOe, 1'b0);
      hostRead(2'd1, rd); chk("R8 data value", rd, d);
      hostRead(2'd3, rd); chk("R10 buffer full cleared", rd & 8'h04, 8'h00);
      hostWrite(2'd3, 8'h1F);
    end
    i2cStop();

    // R7 compare write during ACK clock
    addrSeq();
    sendByte(8'h33, 1'b1, HI_PAT, ack);
    chk("R7 data still acked", ack, 1'b1);
    hostWrite(2'd0, HI_PAT); waitCyc(2);
    i2cStop();
    hostWrite(2'd3, 8'h1F);

    // R9 stretching
    hostWrite(2'd2, 8'h05);
    addrSeq();
    for (int k = 0; k < 2; k++) begin
      logic [7:0] d;
      d = (k == 0) ? 8'h96 : 8'h69;
      sendByte(d, 1'b0, 8'h0, ack);
      chk("R9 data ack with stretch", ack, 1'b1);
      chk("R9 SCL held after byte", sclOe, 1'b1);
      hostRead(2'd2, rd); chk("R9 release bit cleared", rd, 8'h01);
      hostRead(2'd1, rd); chk("R9 stretched data value", rd, d);
      waitCyc(2 * HALF);
      chk("R9 still held before release", sclOe, 1'b1);
      hostWrite(2'd2, 8'h05); waitCyc(1);
      chk("R9 release bit frees SCL", sclOe, 1'b0);
    end
    i2cStop();
    hostWrite(2'd2, 8'h04);
    hostWrite(2'd3, 8'h1F);

    // R11 stop returns to idle
    addrSeq();
    sendByte(8'h11, 1'b0, 8'h0, ack);
    chk("R11 data acked before stop", ack, 1'b1);
    hostRead(2'd1, rd);
    i2cStop();
    hostRead(2'd3, rd); chk("R11 stop seen", rd & 8'h18, 8'h10);
    hostWrite(2'd3, 8'h1F);
    i2cStart();
    sendByte(8'h22, 1'b0, 8'h0, ack);
    chk("R11 no ack without new address", ack, 1'b0);
    hostRead(2'd3, rd); chk("R11 no data after stop", rd & 8'h07, 8'h00);
    i2cStop();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule